// File: doc/BRIEF.md
# External-Edge Timer with Phase-Sampled Synchronizer and Shared Scaler

This block is an 8-bit timer/counter that advances on edges of an external clock pin which has no fixed relation to the oscillator clock. The pin is first conditioned by an edge-polarity select. It then optionally passes through an 8-bit ripple divider, which is clocked directly by the pin edges.

The resulting count signal is not used as a clock by the timer. It is sampled at two fixed phases of a four-phase instruction cycle, so each incoming edge reaches the timer only after a short synchronization delay. A count edge is lost when the signal does not hold its level across one of those sample points.

The single divider is shared. A scaler-assign input hands it either to the timer as a prescaler or to a watchdog tick path as a postscaler. In the second case the raw pin drives the synchronizer directly. Software can load the timer at any time. A load also empties the divider and blocks counting for two instruction cycles. A sticky overflow flag records each wrap of the timer.

Top module: `ext_clk_timer`

## Requirements
- R1: While reset is held, `tmr_q` is 0 and `ovf_flag` is 0. With `wdt_raw` low and `ratio` 0, `wdt_tick` is 0.
- R2: The oscillator clock runs a 2-bit phase counter that starts at phase 0 after reset. The count signal is captured on the oscillator edges that end phases 1 and 3, which are the second and fourth phases. A low-to-high change between two captures increments `tmr_q` by one. With `scl_to_wdt`=1 the count signal is `ext_pin` XOR `edge_fall`, and a pulse that holds high for at least 2 oscillator periods and low for at least 2 periods is counted exactly once.
- R3: Narrower pulses are counted only when the capture model of R2 sees them. For example, a pulse train that is 1 period high and 1 period low is counted at most once over any number of pulses.
- R4: An increment appears one oscillator edge after the capture edge that saw the rising level, never on the edge of the pin change. `tmr_q` never increments on two consecutive oscillator edges.
- R5: With `scl_to_wdt`=0 the divider counts rising edges of the count signal, and the timer sees divider bit `ratio`. This gives a prescale of 2^(ratio+1), from 1:2 for ratio 0 to 1:256 for ratio 7.
- R6: `edge_fall`=1 counts falling edges of `ext_pin`. Its rising edges then have no effect.
- R7: An increment from 0xFF wraps `tmr_q` to 0x00 and sets `ovf_flag`. The flag stays set until `ovf_clr` is high on a clock edge. A set on the same edge as the clear takes priority.
- R8: When `wr_en` is high on an edge, `tmr_q` loads `wr_data` and the divider is cleared to 0. Increments are then ignored on the following 8 oscillator edges, which are two instruction cycles.
- R9: With `scl_to_wdt`=1 the divider counts rising edges of `wdt_raw`. `wdt_tick` is then `wdt_raw` for ratio 0, or else divider bit ratio-1, a 1:2^ratio postscale. `wdt_raw` never changes `tmr_q`. With `scl_to_wdt`=0, `wdt_tick` equals `wdt_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four periods form one instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_raw | input | 1 | Raw watchdog timebase tick |
| scl_to_wdt | input | 1 | 1 assigns the divider to the watchdog, 0 to the timer |
| ratio | input | 3 | Divider tap select |
| edge_fall | input | 1 | 1 counts falling pin edges |
| wr_en | input | 1 | Timer load strobe |
| wr_data | input | 8 | Timer load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_q | output | 8 | Timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Postscaled watchdog tick; each rising edge is one tick |

## Verification
The bench uses the default parameters: an 8-bit timer, an 8-bit divider and an 8-edge load hold. With these, a wrap is reached in two pulses from a loaded 0xFE. The fastest ratio settings, the 1-period pulses that defeat the two-phase capture, and the whole hold window all fit in a few hundred cycles. A behavioural capture model, compared on every clock, predicts which narrow pulses survive.

// File: rtl/ext_clk_timer.sv
module ext_clk_timer #(
  parameter int TW = 8,
  parameter int PW = 8,
  parameter int HOLD_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_pin,
  input  logic          wdt_raw,
  input  logic          scl_to_wdt,
  input  logic [$clog2(PW)-1:0] ratio,
  input  logic          edge_fall,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          ovf_clr,
  output logic [TW-1:0] tmr_q,
  output logic          ovf_flag,
  output logic          wdt_tick
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [1:0]    ph;
  logic          seen_q, inc_q, clr_q;
  logic [PW-1:0] scl;
  logic [HW-1:0] hold;

  wire cnt_sig = ext_pin ^ edge_fall;
  wire scl_clk = scl_to_wdt ? wdt_raw : cnt_sig;
  wire scl_rst = ~rst_n | clr_q;
  wire tmr_in  = scl_to_wdt ? cnt_sig : scl[ratio];
  wire capture = ph[0];
  wire bump    = ~wr_en & (hold == '0) & inc_q;

  always_ff @(posedge scl_clk or posedge scl_rst)
    if (scl_rst) scl <= '0;
    else         scl <= scl + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      seen_q   <= 1'b0;
      inc_q    <= 1'b0;
      clr_q    <= 1'b0;
      hold     <= '0;
      tmr_q    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      ph    <= ph + 1'b1;
      clr_q <= wr_en;
      if (capture) begin
        seen_q <= tmr_in;
        inc_q  <= tmr_in & ~seen_q;
      end else begin
        inc_q  <= 1'b0;
      end
      if (wr_en) begin
        tmr_q <= wr_data;
        hold  <= HW'(HOLD_CYC);
      end else if (hold != '0) begin
        hold  <= hold - 1'b1;
      end else if (inc_q) begin
        tmr_q <= tmr_q + 1'b1;
      end
      if (bump && (&tmr_q)) ovf_flag <= 1'b1;
      else if (ovf_clr)     ovf_flag <= 1'b0;
    end
  end

  assign wdt_tick = (!scl_to_wdt || ratio == '0) ? wdt_raw : scl[ratio - 1'b1];
endmodule

module ext_clk_timer_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [TW-1:0] wr_data,
  input logic          ovf_clr,
  input logic [TW-1:0] tmr_q,
  input logic          ovf_flag
);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
  // R7
  wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && (&tmr_q) |=> (tmr_q != '0 || ovf_flag));
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 1'b1));
  // R4
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en) && tmr_q != $past(tmr_q)) |=> $stable(tmr_q));
  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tmr_q == $past(wr_data));
  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && !wr_en |=> $stable(tmr_q));
endmodule

bind ext_clk_timer ext_clk_timer_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .ovf_clr(ovf_clr), .tmr_q(tmr_q), .ovf_flag(ovf_flag)
);

// File: tb/sim_ext_clk_timer.sv
module sim_ext_clk_timer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ext_pin, wdt_raw, scl_to_wdt, edge_fall, wr_en, ovf_clr;
  logic [2:0] ratio;
  logic [7:0] wr_data, tmr_q;
  logic ovf_flag, wdt_tick;

  int errs = 0, checks = 0;
  int pcount = 0;
  int m_ph, m_tmr, m_hold;
  bit m_seen, m_inc, m_ovf;
  bit done = 0;

  ext_clk_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wdt_raw(wdt_raw),
    .scl_to_wdt(scl_to_wdt), .ratio(ratio), .edge_fall(edge_fall),
    .wr_en(wr_en), .wr_data(wr_data), .ovf_clr(ovf_clr),
    .tmr_q(tmr_q), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
  );

  function automatic bit model_src();
    if (scl_to_wdt) return ext_pin ^ edge_fall;
    return ((pcount >> ratio) & 1) != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_tmr = 0; m_hold = 0; m_seen = 0; m_inc = 0; m_ovf = 0;
    end else begin
      automatic bit src = model_src();
      automatic bit set_ovf = 0;
      if (wr_en) begin
        m_tmr = wr_data; m_hold = 8;
      end else if (m_hold > 0) begin
        m_hold--;
      end else if (m_inc) begin
        if (m_tmr == 255) set_ovf = 1;
        m_tmr = (m_tmr + 1) % 256;
      end
      if (set_ovf) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      if (m_ph == 1 || m_ph == 3) begin
        m_inc = src && !m_seen;
        m_seen = src;
      end else begin
        m_inc = 0;
      end
      m_ph = (m_ph + 1) % 4;
      if (wr_en) pcount = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n === 1'b1 && !done) begin
      chk("R3 cycle model tmr", tmr_q, m_tmr);
      chk("R7 cycle model ovf", ovf_flag, m_ovf);
    end

  task automatic finish_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(bit v);
    bit old = ext_pin ^ edge_fall;
    if (!scl_to_wdt && !old && v) pcount++;
    ext_pin = v ^ edge_fall;
  endtask

  task automatic set_wdt(bit v);
    if (scl_to_wdt && !wdt_raw && v) pcount++;
    wdt_raw = v;
  endtask

  task automatic pulse(int hi, int lo);
    set_src(1); tick(hi);
    set_src(0); tick(lo);
  endtask

  task automatic load(int d);
    wr_en = 1; wr_data = 8'(d);
    tick(1);
    wr_en = 0;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_up();
    end
  end

  initial begin
    int base;
    rst_n = 0; ext_pin = 0; wdt_raw = 0; scl_to_wdt = 1; edge_fall = 0;
    wr_en = 0; ovf_clr = 0; ratio = 0; wr_data = 0;
    tick(3);
    chk("R1 reset tmr", tmr_q, 0);
    chk("R1 reset ovf", ovf_flag, 0);
    chk("R1 reset wdt_tick", wdt_tick, 0);
    rst_n = 1;
    tick(2);

    // R2: wide pulses, no prescaler
    load(0); tick(10);
    repeat (5) pulse(2, 2);
    tick(8);
    chk("R2 wide pulses counted", tmr_q, 5);

    // R3: 1-high/1-low train seen as constant by the capture
    base = tmr_q;
    repeat (6) pulse(1, 1);
    tick(8);
    chk("R3 narrow train at most one count", (tmr_q - base) <= 1, 1);
    repeat (6) pulse(1, 3);
    repeat (4) pulse(3, 1);
    tick(8);

    // R4: latency check on a single pulse
    load(0); tick(10);
    set_src(1);
    @(posedge clk); #1;
    chk("R4 no increment on pin edge", tmr_q, 0);
    tick(4);
    chk("R4 increment after capture", tmr_q, 1);
    set_src(0); tick(6);

    // R6: falling edges
    ext_pin = 1; edge_fall = 1;
    tick(4);
    base = tmr_q;
    repeat (3) pulse(2, 2);
    tick(8);
    chk("R6 falling edges counted", tmr_q - base, 3);
    ext_pin = 0; edge_fall = 0;
    tick(4);

    // R5: prescaler 1:4 then 1:2
    scl_to_wdt = 0; ratio = 1;
    load(0); tick(10);
    repeat (12) pulse(2, 2);
    tick(8);
    chk("R5 ratio 1 divides by 4", tmr_q, 3);
    ratio = 0;
    load(0); tick(10);
    repeat (8) pulse(1, 1);
    tick(8);
    chk("R5 ratio 0 divides by 2", tmr_q, 4);

    // R8: load clears the divider
    ratio = 1;
    load(0); tick(10);
    pulse(2, 2);
    load(32); tick(10);
    pulse(2, 2);
    tick(8);
    chk("R8 divider cleared by load", tmr_q, 32);

    // R8: increments inhibited after load
    ratio = 0; scl_to_wdt = 1;
    load(64);
    pulse(2, 2);
    tick(8);
    chk("R8 increment inhibited", tmr_q, 64);

    // R7: wrap and sticky overflow
    load(254); tick(10);
    pulse(2, 2); tick(2);
    chk("R7 at 0xFF", tmr_q, 255);
    chk("R7 no flag before wrap", ovf_flag, 0);
    pulse(2, 2); tick(2);
    chk("R7 wrapped", tmr_q, 0);
    chk("R7 flag set", ovf_flag, 1);
    pulse(2, 2); tick(2);
    chk("R7 flag sticky", ovf_flag, 1);
    ovf_clr = 1; tick(1); ovf_clr = 0; tick(1);
    chk("R7 flag cleared", ovf_flag, 0);

    // R9: watchdog postscaler 1:4
    ratio = 2;
    load(85); tick(10);
    repeat (2) begin set_wdt(1); tick(2); set_wdt(0); tick(2); end
    chk("R9 tick high after 2", wdt_tick, 1);
    repeat (2) begin set_wdt(1); tick(2); set_wdt(0); tick(2); end
    chk("R9 tick low after 4", wdt_tick, 0);
    chk("R9 wdt_raw ignored by timer", tmr_q, 85);
    ratio = 0;
    set_wdt(1); tick(1);
    chk("R9 ratio 0 passes raw high", wdt_tick, 1);
    set_wdt(0); tick(1);
    chk("R9 ratio 0 passes raw low", wdt_tick, 0);
    scl_to_wdt = 0; ratio = 3;
    load(0); tick(2);
    wdt_raw = 1; tick(1);
    chk("R9 timer-assigned passes raw", wdt_tick, 1);
    wdt_raw = 0; tick(4);

    finish_up();
  end
endmodule